// File: doc/BRIEF.md
# VGA General Control Register Unit

This unit holds the two general control registers of a VGA-style display controller behind an 8-bit I/O port interface: a miscellaneous output register and a feature control register. Each register is written at one port address and read back at another. The feature control write address moves between a monochrome location and a colour location, and bit 0 of the miscellaneous register picks which one is live.

From the stored bits the unit drives several outputs: a display-memory access enable, an odd/even page select, and a registered clock-source select. When an external configuration enable is active and the miscellaneous clock field holds 10, the clock select is remapped through the feature register. The unit also drives a registered sync output, which carries vertical sync alone or the OR of vertical sync and display enable.

A host bus mux combines the read data of this unit with that of other units. When no decoded read address is active, this unit drives zero and keeps its read-valid output low.

Top module: `vga_genctl_top`

## Requirements
- R1: After reset both registers hold zero, and clk_sel, ram_en, page_lo and sync_out are all 0.
- R2: A write strobe at port 3C2h loads the miscellaneous register on that clock edge. A read at 3CCh returns the value with bits 7, 6 and 4 forced to zero (mask 2Fh).
- R3: The feature register is written at 3BAh when miscellaneous bit 0 is 0, and at 3DAh when it is 1. A write to the other of the two addresses leaves the register unchanged.
- R4: A read at 3CAh returns the feature register with bits 7:4 and 2 forced to zero (mask 0Bh), whatever the value of miscellaneous bit 0.
- R5: When io_rd is low, or the address is neither 3CCh nor 3CAh, io_rdata is 00h and io_rvalid is 0. A read at 3CCh or 3CAh sets io_rvalid to 1.
- R6: ram_en follows miscellaneous bit 1 (1 allows memory access). page_lo follows miscellaneous bit 5 (1 selects the lower 64 KB page, 0 the upper).
- R7: One clock after the miscellaneous register changes, clk_sel shows {0, misc[3:2]}. This is the direct source 0 to 3, and it applies whenever cfg_remap_en is 0 or misc[3:2] is not 10.
- R8: When cfg_remap_en is 1 and misc[3:2] is 10, clk_sel shows {1, feat[1:0]} one clock later. The codes are 4 for preset A, 5 for preset B, 6 for user-defined and 7 for preset C.
- R9: One clock after its inputs, sync_out equals vsync_in when feature bit 3 is 0, and equals vsync_in OR de_in when feature bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| io_rvalid | output | 1 | High when a decoded read address is read |
| cfg_remap_en | input | 1 | Enables clock remapping through the feature register |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| de_in | input | 1 | Display enable from the timing generator |
| clk_sel | output | 3 | Registered clock-source code (0-3 direct, 4-7 remapped) |
| ram_en | output | 1 | Display memory access enable |
| page_lo | output | 1 | Odd/even page select (1 selects the lower page) |
| sync_out | output | 1 | Registered sync, optionally merged with display enable |

## Verification
The hardest case to reach is a feature-register write that the decoder must drop because it targets the inactive address. It only occurs after the miscellaneous register has been written to set the range. The bench first sets the monochrome range, writes a known feature value, and then writes a different value at the colour address. Reading 3CAh then shows that nothing changed. The remapped clock codes also need a two-register setup, so the vector table writes both registers in order, with the feature write aimed at whichever address the new range bit enables, before it samples clk_sel.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  localparam int DW = 8;

  // stored-bit keep masks; all other positions read as zero
  localparam logic [DW-1:0] MISC_KEEP = 8'h2F;
  localparam logic [DW-1:0] FEAT_KEEP = 8'h0B;

  // clock code: {remapped, source}
  function automatic logic [2:0] pick_clk(input logic [1:0] misc_clk,
                                          input logic [1:0] feat_clk,
                                          input logic       remap_en);
    if (remap_en && (misc_clk == 2'b10)) return {1'b1, feat_clk};
    return {1'b0, misc_clk};
  endfunction

  function automatic logic merge_sync(input logic vs, input logic de, input logic mix);
    return vs | (de & mix);
  endfunction
endpackage

// File: rtl/vgc_io_decode.sv
module vgc_io_decode #(
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] MISC_WR       = 16'h03C2,
  parameter logic [ADDR_W-1:0] MISC_RD       = 16'h03CC,
  parameter logic [ADDR_W-1:0] FEAT_RD       = 16'h03CA,
  parameter logic [ADDR_W-1:0] FEAT_WR_MONO  = 16'h03BA,
  parameter logic [ADDR_W-1:0] FEAT_WR_COLOR = 16'h03DA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              color_sel,
  output logic              misc_we,
  output logic              feat_we,
  output logic              feat_drop,
  output logic              misc_re,
  output logic              feat_re
);
  logic [ADDR_W-1:0] feat_live, feat_dead;

  always_comb begin
    feat_live = color_sel ? FEAT_WR_COLOR : FEAT_WR_MONO;
    feat_dead = color_sel ? FEAT_WR_MONO  : FEAT_WR_COLOR;
  end

  assign misc_we   = wr && (addr == MISC_WR);
  assign feat_we   = wr && (addr == feat_live);
  assign feat_drop = wr && (addr == feat_dead);
  assign misc_re   = rd && (addr == MISC_RD);
  assign feat_re   = rd && (addr == FEAT_RD);
endmodule

// File: rtl/vgc_regfile.sv
module vgc_regfile
  import vgc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          misc_we,
  input  logic          feat_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] misc_q,
  output logic [DW-1:0] feat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q <= '0;
      feat_q <= '0;
    end else begin
      if (misc_we) misc_q <= wdata & MISC_KEEP;
      if (feat_we) feat_q <= wdata & FEAT_KEEP;
    end
  end
endmodule

// File: rtl/vgc_clk_sync.sv
module vgc_clk_sync
  import vgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] misc_clk,
  input  logic [1:0] feat_clk,
  input  logic       remap_en,
  input  logic       vsync,
  input  logic       de,
  input  logic       mix,
  output logic [2:0] clk_sel,
  output logic       sync_out
);
  logic [2:0] clk_next;
  logic       sync_next;

  always_comb begin
    clk_next  = pick_clk(misc_clk, feat_clk, remap_en);
    sync_next = merge_sync(vsync, de, mix);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel  <= '0;
      sync_out <= 1'b0;
    end else begin
      clk_sel  <= clk_next;
      sync_out <= sync_next;
    end
  end
endmodule

// File: rtl/vga_genctl_top.sv
module vga_genctl_top
  import vgc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_rvalid,
  input  logic              cfg_remap_en,
  input  logic              vsync_in,
  input  logic              de_in,
  output logic [2:0]        clk_sel,
  output logic              ram_en,
  output logic              page_lo,
  output logic              sync_out
);
  logic [DW-1:0] misc_q, feat_q;
  logic misc_we, feat_we, feat_drop, misc_re, feat_re;

  vgc_io_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .color_sel(misc_q[0]),
    .misc_we(misc_we), .feat_we(feat_we), .feat_drop(feat_drop),
    .misc_re(misc_re), .feat_re(feat_re)
  );

  vgc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .misc_we(misc_we), .feat_we(feat_we),
    .wdata(io_wdata), .misc_q(misc_q), .feat_q(feat_q)
  );

  vgc_clk_sync u_cs (
    .clk(clk), .rst_n(rst_n), .misc_clk(misc_q[3:2]), .feat_clk(feat_q[1:0]),
    .remap_en(cfg_remap_en), .vsync(vsync_in), .de(de_in), .mix(feat_q[3]),
    .clk_sel(clk_sel), .sync_out(sync_out)
  );

  always_comb begin
    io_rdata = '0;
    if (misc_re)      io_rdata = misc_q & MISC_KEEP;
    else if (feat_re) io_rdata = feat_q & FEAT_KEEP;
  end

  assign io_rvalid = misc_re | feat_re;
  assign ram_en    = misc_q[1];
  assign page_lo   = misc_q[5];
endmodule

// File: rtl/vga_genctl_chk.sv
module vga_genctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        io_rvalid,
  input logic        cfg_remap_en,
  input logic        vsync_in,
  input logic        de_in,
  input logic [2:0]  clk_sel,
  input logic        ram_en,
  input logic [7:0]  feat_q,
  input logic        feat_drop,
  input logic        sync_out
);
  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rvalid |-> (io_rdata == 8'h00));

  // R2
  misc_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 16'h03CC) |-> ((io_rdata & 8'hD0) == 8'h00));

  // R4
  feat_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 16'h03CA) |-> ((io_rdata & 8'hF4) == 8'h00));

  // R3
  feat_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feat_drop |=> $stable(feat_q));

  // R6
  ram_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h03C2) |=> (ram_en == $past(io_wdata[1])));

  // R7
  direct_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_remap_en |=> !clk_sel[2]);

  // R9
  sync_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_out == ($past(vsync_in) | ($past(de_in) & $past(feat_q[3])))));
endmodule

bind vga_genctl_top vga_genctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .cfg_remap_en(cfg_remap_en), .vsync_in(vsync_in), .de_in(de_in),
  .clk_sel(clk_sel), .ram_en(ram_en), .feat_q(feat_q), .feat_drop(feat_drop),
  .sync_out(sync_out)
);

// File: tb/vga_genctl_top_test.sv
module vga_genctl_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        cfg_remap_en = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
  logic [2:0]  clk_sel;
  logic        ram_en, page_lo, sync_out;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_genctl_top uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_remap_en(cfg_remap_en), .vsync_in(vsync_in), .de_in(de_in),
    .clk_sel(clk_sel), .ram_en(ram_en), .page_lo(page_lo), .sync_out(sync_out)
  );

  // {misc, feat, cfg, expected clk_sel}
  localparam logic [19:0] VEC [8] = '{
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'h04, 8'h00, 1'b1, 3'd1},
    {8'h08, 8'h00, 1'b0, 3'd2},
    {8'h0C, 8'h02, 1'b1, 3'd3},
    {8'h08, 8'h00, 1'b1, 3'd4},
    {8'h09, 8'h01, 1'b1, 3'd5},
    {8'h09, 8'h02, 1'b1, 3'd6},
    {8'h08, 8'h03, 1'b1, 3'd7}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata; v = io_rvalid;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R1
    check("R1 clk_sel", {5'd0, clk_sel}, 8'h00);
    check("R1 ram_en", {7'd0, ram_en}, 8'h00);
    check("R1 page_lo", {7'd0, page_lo}, 8'h00);
    check("R1 sync_out", {7'd0, sync_out}, 8'h00);
    rst_n = 1'b1;
    rd(16'h03CC, d, v); check("R1 misc", d, 8'h00);
    rd(16'h03CA, d, v); check("R1 feat", d, 8'h00);

    // table walk: R7 / R8
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m, f;
      m = VEC[i][19:12]; f = VEC[i][11:4];
      cfg_remap_en = VEC[i][3];
      wr(16'h03C2, m);
      wr(m[0] ? 16'h03DA : 16'h03BA, f);
      @(negedge clk);
      check(VEC[i][2] ? "R8 remapped clk" : "R7 direct clk", {5'd0, clk_sel}, {5'd0, VEC[i][2:0]});
    end

    // R2 readback mask
    wr(16'h03C2, 8'hFE);
    rd(16'h03CC, d, v); check("R2 misc readback", d, 8'h2E);
    check("R5 rvalid misc", {7'd0, v}, 8'h01);
    // R6
    check("R6 ram_en", {7'd0, ram_en}, 8'h01);
    check("R6 page_lo", {7'd0, page_lo}, 8'h01);
    wr(16'h03C2, 8'h00);
    check("R6 ram_en off", {7'd0, ram_en}, 8'h00);
    check("R6 page_lo off", {7'd0, page_lo}, 8'h00);

    // R3 mono range: live 3BA, dead 3DA
    wr(16'h03BA, 8'h01);
    rd(16'h03CA, d, v); check("R3 mono write", d, 8'h01);
    wr(16'h03DA, 8'h0A);
    rd(16'h03CA, d, v); check("R3 dead colour addr", d, 8'h01);
    // colour range
    wr(16'h03C2, 8'h01);
    wr(16'h03BA, 8'h03);
    rd(16'h03CA, d, v); check("R3 dead mono addr", d, 8'h01);
    wr(16'h03DA, 8'hFF);
    rd(16'h03CA, d, v); check("R4 feat readback mask", d, 8'h0B);
    check("R5 rvalid feat", {7'd0, v}, 8'h01);

    // R5 non-decoded reads
    rd(16'h03C2, d, v); check("R5 write-only addr data", d, 8'h00);
    check("R5 write-only addr valid", {7'd0, v}, 8'h00);
    @(negedge clk); io_addr = 16'h03CC; io_rd = 1'b0; #1;
    check("R5 no strobe data", io_rdata, 8'h00);
    check("R5 no strobe valid", {7'd0, io_rvalid}, 8'h00);

    // R9 merge on (feat bit3 = 1 now)
    @(negedge clk); vsync_in = 1'b0; de_in = 1'b1;
    @(negedge clk); check("R9 merge de", {7'd0, sync_out}, 8'h01);
    vsync_in = 1'b1; de_in = 1'b0;
    @(negedge clk); check("R9 merge vs", {7'd0, sync_out}, 8'h01);
    vsync_in = 1'b0;
    @(negedge clk); check("R9 merge idle", {7'd0, sync_out}, 8'h00);
    wr(16'h03DA, 8'h00);
    de_in = 1'b1;
    @(negedge clk); check("R9 plain de blocked", {7'd0, sync_out}, 8'h00);
    vsync_in = 1'b1;
    @(negedge clk); check("R9 plain vs", {7'd0, sync_out}, 8'h01);
    vsync_in = 1'b0; de_in = 1'b0;

    // R1 again via mid-run reset
    wr(16'h03C2, 8'h0E);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset clk_sel", {5'd0, clk_sel}, 8'h00);
    check("R1 reset ram_en", {7'd0, ram_en}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule